// File: doc/BRIEF.md
# Block Cipher Data Handshake Tracker

This block sits between the software-visible data words of a 128-bit block cipher and the cipher engine itself. Software fills four input words, optionally four chaining words, and drains four output words. The block records which words have been touched, decides when the engine may begin a block, holds the engine in its final cycle when a finished block would destroy unread output, and reports status flags. The cipher datapath is not part of this block: the engine only receives a start pulse and answers with a last-cycle request.

Two operating styles are supported. In automatic operation a block begins as soon as all input words have been written, and the engine is held back rather than overwriting unread output. In manual operation a block begins only on an explicit trigger, finished output always replaces the previous output, and a sticky flag records any replaced output that was never read. The chaining modes that use an initial vector (CBC and CTR) refuse to begin until every vector word has been written since the last configuration write. A configuration write clears all tracking state.

Top module: `hs_tracker`

## Requirements
- R1: After reset, input_ready is 1 and output_valid, stall, output_lost and engine_start are 0.
- R2: A block is available only once each input word (strobe bit i marks word i) has been written at least once, in any order; in automatic operation engine_start is 1 in the cycle after the edge that records the last missing word, and never on a partial set.
- R3: input_ready is 0 while at least one input word has been written but not yet loaded, and returns to 1 in the cycle after engine_start.
- R4: With manual_mode=1, engine_start needs a pending trigger; a start_trig pulse given while manual_mode=0 or while mode_code decodes to NONE is discarded and does not start a later block.
- R5: mode_code encodes ECB=0, CBC=1, CFB=2, OFB=3, CTR=4, NONE=5..7; for CBC and CTR each IV word must have been written since the last ctrl_wr before engine_start; ECB ignores the IV words; NONE never starts.
- R6: output_valid rises in the cycle after an accepted engine completion and falls in the cycle after the edge at which the last of the four output words has been read.
- R7: With manual_mode=0, when eng_last is 1 while output_valid is 1, stall is 1 and the completion is not accepted; once the output has been fully read, stall drops and the completion is accepted at the next edge.
- R8: With manual_mode=1, stall stays 0 and a completion that replaces unread output sets output_lost, which stays 1 until ctrl_wr.
- R9: ctrl_wr clears input, IV and output tracking, the pending trigger, the running flag, output_valid and output_lost from the next cycle on.
- R10: engine_start is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| manual_mode | input | 1 | 1 = manual operation, 0 = automatic |
| mode_code | input | 3 | Chaining mode code (see R5) |
| ctrl_wr | input | 1 | Configuration write pulse, starts a new message |
| start_trig | input | 1 | Manual start trigger pulse |
| in_wr | input | WORDS | Per-word input write strobes |
| iv_wr | input | WORDS | Per-word IV write strobes |
| out_rd | input | WORDS | Per-word output read strobes |
| eng_last | input | 1 | Engine is in its last cycle and wants to complete |
| engine_start | output | 1 | Single-cycle engine start pulse |
| input_ready | output | 1 | Input words free for new data |
| output_valid | output | 1 | Unread output present |
| stall | output | 1 | Engine held in its last cycle |
| output_lost | output | 1 | Sticky: unread output was overwritten |

## Verification
All tracking flags are registered, so a strobe applied before edge k is seen in status after edge k, and engine_start, being decoded from those registers, appears in the cycle after the edge that completes the input set; stall is decoded combinationally from eng_last and the registered output state, so it is due in the same cycle eng_last is driven. output_valid follows an accepted completion or a final read by one edge. The bench drives inputs shortly after each rising edge and samples a moment later, and its scoreboard queue holds the cycle number at which each start pulse is expected, which a monitor compares on every observed pulse.

// File: rtl/hs_trk_pkg.sv
package hs_trk_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        CM_ECB  = 3'd0,
        CM_CBC  = 3'd1,
        CM_CFB  = 3'd2,
        CM_OFB  = 3'd3,
        CM_CTR  = 3'd4,
        CM_NONE = 3'd5
    } chain_mode_e;

    // Gate terms that together permit an engine start
    typedef struct packed {
        logic data_full;
        logic iv_ok;
        logic mode_ok;
        logic trig_ok;
        logic idle;
    } start_gate_t;

    function automatic chain_mode_e decode_mode(logic [MODE_W-1:0] code);
        chain_mode_e m;
        case (code)
            3'd0:    m = CM_ECB;
            3'd1:    m = CM_CBC;
            3'd2:    m = CM_CFB;
            3'd3:    m = CM_OFB;
            3'd4:    m = CM_CTR;
            default: m = CM_NONE;
        endcase
        return m;
    endfunction

    function automatic logic mode_needs_iv(chain_mode_e m);
        return (m == CM_CBC) || (m == CM_CTR);
    endfunction

    function automatic logic gate_open(start_gate_t g);
        return g.data_full & g.iv_ok & g.mode_ok & g.trig_ok & g.idle;
    endfunction

endpackage

// File: rtl/word_mask_tracker.sv
module word_mask_tracker #(
    parameter int WORDS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             restart,
    input  logic [WORDS-1:0] strb,
    output logic [WORDS-1:0] seen,
    output logic             all_seen,
    output logic             any_seen,
    output logic             all_next
);
    logic [WORDS-1:0] merged;

    assign merged   = seen | strb;
    assign all_seen = &seen;
    assign any_seen = |seen;
    assign all_next = &merged;

    // flush drops same-cycle strobes; restart keeps them for the next set
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            seen <= '0;
        end else if (restart) begin
            seen <= strb;
        end else begin
            seen <= merged;
        end
    end
endmodule

// File: rtl/hs_start_gate.sv
module hs_start_gate
    import hs_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              manual_mode,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              start_trig,
    input  logic              in_full,
    input  logic              iv_full,
    input  logic              busy,
    output logic              start,
    output logic              trig_pend,
    output logic              needs_iv
);
    chain_mode_e mode;
    start_gate_t gate;
    logic        mode_ok;
    logic        trig_take;

    assign mode      = decode_mode(mode_code);
    assign mode_ok   = (mode != CM_NONE);
    assign needs_iv  = mode_needs_iv(mode);
    assign trig_take = start_trig & manual_mode & mode_ok;

    always_comb begin
        gate.data_full = in_full;
        gate.iv_ok     = ~needs_iv | iv_full;
        gate.mode_ok   = mode_ok;
        gate.trig_ok   = ~manual_mode | trig_pend;
        gate.idle      = ~busy;
    end

    assign start = gate_open(gate) & ~ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            trig_pend <= 1'b0;
        end else if (trig_take) begin
            trig_pend <= 1'b1;
        end else if (start) begin
            trig_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/hs_out_ctrl.sv
module hs_out_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic manual_mode,
    input  logic start,
    input  logic eng_last,
    input  logic rd_done,
    output logic busy,
    output logic accept,
    output logic out_valid,
    output logic stall,
    output logic lost
);
    assign stall  = busy & eng_last & ~manual_mode & out_valid;
    assign accept = busy & eng_last & ~stall & ~ctrl_wr;

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (accept) begin
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            out_valid <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
        end else if (out_valid && rd_done) begin
            out_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_wr) begin
            lost <= 1'b0;
        end else if (accept && manual_mode && out_valid && !rd_done) begin
            lost <= 1'b1;
        end
    end
endmodule

// File: rtl/hs_tracker.sv
module hs_tracker
    import hs_trk_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              manual_mode,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              ctrl_wr,
    input  logic              start_trig,
    input  logic [WORDS-1:0]  in_wr,
    input  logic [WORDS-1:0]  iv_wr,
    input  logic [WORDS-1:0]  out_rd,
    input  logic              eng_last,
    output logic              engine_start,
    output logic              input_ready,
    output logic              output_valid,
    output logic              stall,
    output logic              output_lost
);
    logic             in_all, in_any, in_all_nx;
    logic             iv_all, iv_any, iv_all_nx;
    logic             out_all, out_any, rd_done;
    logic [WORDS-1:0] in_seen, iv_seen, out_seen;
    logic [WORDS-1:0] rd_strb;
    logic             busy, accept, trig_pend, needs_iv;

    assign rd_strb = out_rd & {WORDS{output_valid & ~accept}};

    word_mask_tracker #(.WORDS(WORDS)) u_in_trk (
        .clk(clk), .rst(rst), .flush(ctrl_wr), .restart(engine_start),
        .strb(in_wr), .seen(in_seen), .all_seen(in_all),
        .any_seen(in_any), .all_next(in_all_nx)
    );

    word_mask_tracker #(.WORDS(WORDS)) u_iv_trk (
        .clk(clk), .rst(rst), .flush(ctrl_wr), .restart(1'b0),
        .strb(iv_wr), .seen(iv_seen), .all_seen(iv_all),
        .any_seen(iv_any), .all_next(iv_all_nx)
    );

    word_mask_tracker #(.WORDS(WORDS)) u_out_trk (
        .clk(clk), .rst(rst), .flush(ctrl_wr), .restart(accept),
        .strb(rd_strb), .seen(out_seen), .all_seen(out_all),
        .any_seen(out_any), .all_next(rd_done)
    );

    hs_start_gate u_gate (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .manual_mode(manual_mode),
        .mode_code(mode_code), .start_trig(start_trig), .in_full(in_all),
        .iv_full(iv_all), .busy(busy), .start(engine_start),
        .trig_pend(trig_pend), .needs_iv(needs_iv)
    );

    hs_out_ctrl u_out (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .manual_mode(manual_mode),
        .start(engine_start), .eng_last(eng_last), .rd_done(rd_done),
        .busy(busy), .accept(accept), .out_valid(output_valid),
        .stall(stall), .lost(output_lost)
    );

    assign input_ready = ~in_any;
endmodule

// File: rtl/hs_trk_chk.sv
module hs_trk_chk #(
    parameter int WORDS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             manual_mode,
    input logic             ctrl_wr,
    input logic [WORDS-1:0] in_wr,
    input logic             engine_start,
    input logic             input_ready,
    input logic             output_valid,
    input logic             stall,
    input logic             output_lost,
    input logic             trig_pend,
    input logic             iv_all,
    input logic             needs_iv,
    input logic             busy
);
    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        engine_start |=> !engine_start);

    // R2
    start_full_chk: assert property (@(posedge clk) disable iff (rst)
        engine_start |-> (!input_ready && !busy));

    // R3
    ready_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (engine_start && in_wr == '0 && !ctrl_wr) |=> input_ready);

    // R4
    manual_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (engine_start && manual_mode) |-> trig_pend);

    // R5
    iv_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (engine_start && needs_iv) |-> iv_all);

    // R7
    stall_auto_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!manual_mode && output_valid));

    // R8
    lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (output_lost && !ctrl_wr) |=> output_lost);

    // R9
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (!output_valid && !output_lost && input_ready && !busy));
endmodule

bind hs_tracker hs_trk_chk #(.WORDS(WORDS)) u_chk (
    .clk(clk), .rst(rst), .manual_mode(manual_mode), .ctrl_wr(ctrl_wr),
    .in_wr(in_wr), .engine_start(engine_start), .input_ready(input_ready),
    .output_valid(output_valid), .stall(stall), .output_lost(output_lost),
    .trig_pend(trig_pend), .iv_all(iv_all), .needs_iv(needs_iv), .busy(busy)
);

// File: tb/tb_hs_tracker.sv
module tb_hs_tracker;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         manual_mode;
    logic [2:0]   mode_code;
    logic         ctrl_wr, start_trig, eng_last;
    logic [W-1:0] in_wr, iv_wr, out_rd;
    logic         engine_start, input_ready, output_valid, stall, output_lost;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hs_tracker #(.WORDS(W)) dut (
        .clk(clk), .rst(rst), .manual_mode(manual_mode), .mode_code(mode_code),
        .ctrl_wr(ctrl_wr), .start_trig(start_trig), .in_wr(in_wr),
        .iv_wr(iv_wr), .out_rd(out_rd), .eng_last(eng_last),
        .engine_start(engine_start), .input_ready(input_ready),
        .output_valid(output_valid), .stall(stall), .output_lost(output_lost)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: each start pulse must match the next expected cycle
    always @(negedge clk) begin
        if (!rst && engine_start) begin
            int e;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected start actual=%0d expected=none", cyc);
            end else begin
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL R2 start cycle actual=%0d expected=%0d", cyc, e);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_start_next();
        exp_q.push_back(cyc + 1);
    endtask

    task automatic ctrl(logic [2:0] m, logic man);
        mode_code = m; manual_mode = man; ctrl_wr = 1'b1;
        step(); ctrl_wr = 1'b0; #1;
    endtask

    task automatic wr_in(logic [W-1:0] m);
        in_wr = m; step(); in_wr = '0; #1;
    endtask

    task automatic wr_iv(logic [W-1:0] m);
        iv_wr = m; step(); iv_wr = '0; #1;
    endtask

    task automatic rd(logic [W-1:0] m);
        out_rd = m; step(); out_rd = '0; #1;
    endtask

    task automatic trig();
        start_trig = 1'b1; step(); start_trig = 1'b0; #1;
    endtask

    task automatic finish_eng();
        eng_last = 1'b1; step(); eng_last = 1'b0; #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; manual_mode = 1'b0; mode_code = 3'd0; ctrl_wr = 1'b0;
        start_trig = 1'b0; eng_last = 1'b0; in_wr = '0; iv_wr = '0; out_rd = '0;
        repeat (3) @(posedge clk);
        #2; rst = 1'b0; #1;

        // R1 reset state
        chk("R1", "input_ready", input_ready, 1'b1);
        chk("R1", "output_valid", output_valid, 1'b0);
        chk("R1", "stall", stall, 1'b0);
        chk("R1", "output_lost", output_lost, 1'b0);
        chk("R1", "engine_start", engine_start, 1'b0);

        // Automatic ECB, words in scrambled order
        ctrl(3'd0, 1'b0);
        wr_in(4'b0100);
        chk("R3", "ready low after partial write", input_ready, 1'b0);
        wr_in(4'b0001);
        chk("R2", "no start on partial set", engine_start, 1'b0);
        wr_in(4'b1000);
        expect_start_next();
        wr_in(4'b0010);
        chk("R2", "start after last word", engine_start, 1'b1);
        step();
        chk("R10", "start is one cycle", engine_start, 1'b0);
        chk("R3", "ready after load", input_ready, 1'b1);
        finish_eng();
        chk("R6", "valid after completion", output_valid, 1'b1);

        // Automatic stall on unread output
        expect_start_next();
        wr_in(4'hF);
        chk("R2", "start after full write", engine_start, 1'b1);
        step();
        eng_last = 1'b1; #1;
        chk("R7", "stall with unread output", stall, 1'b1);
        step();
        chk("R7", "stall held", stall, 1'b1);
        chk("R7", "old output kept", output_valid, 1'b1);
        rd(4'b0011);
        rd(4'b0100);
        chk("R6", "valid after partial read", output_valid, 1'b1);
        rd(4'b1000);
        chk("R6", "valid falls after all read", output_valid, 1'b0);
        chk("R7", "stall released", stall, 1'b0);
        step();
        chk("R7", "completion accepted after release", output_valid, 1'b1);
        eng_last = 1'b0; #1;
        rd(4'hF);
        chk("R6", "valid falls after read", output_valid, 1'b0);

        // CBC needs every IV word
        ctrl(3'd1, 1'b0);
        wr_in(4'hF);
        step(); step();
        chk("R5", "CBC no start without IV", engine_start, 1'b0);
        wr_iv(4'b0111);
        chk("R5", "CBC no start with partial IV", engine_start, 1'b0);
        expect_start_next();
        wr_iv(4'b1000);
        chk("R5", "CBC start after full IV", engine_start, 1'b1);
        step();
        finish_eng();
        chk("R6", "CBC output valid", output_valid, 1'b1);

        // Control write clears everything, CTR needs fresh IV
        ctrl(3'd4, 1'b0);
        chk("R9", "valid cleared", output_valid, 1'b0);
        chk("R9", "ready after clear", input_ready, 1'b1);
        wr_in(4'hF);
        step();
        chk("R9", "IV tracking cleared", engine_start, 1'b0);
        expect_start_next();
        wr_iv(4'hF);
        chk("R5", "CTR start after IV", engine_start, 1'b1);
        step();
        finish_eng();
        rd(4'hF);

        // Manual mode: trigger needed, overwrite sets lost
        ctrl(3'd0, 1'b1);
        wr_in(4'hF);
        step(); step();
        chk("R4", "manual waits for trigger", engine_start, 1'b0);
        expect_start_next();
        trig();
        chk("R4", "manual start on trigger", engine_start, 1'b1);
        step();
        finish_eng();
        chk("R8", "no lost on first output", output_lost, 1'b0);
        wr_in(4'hF);
        expect_start_next();
        trig();
        chk("R4", "second manual start", engine_start, 1'b1);
        step();
        eng_last = 1'b1; #1;
        chk("R8", "no stall in manual", stall, 1'b0);
        step();
        eng_last = 1'b0; #1;
        chk("R8", "lost set on overwrite", output_lost, 1'b1);
        chk("R8", "new output valid", output_valid, 1'b1);
        rd(4'hF);
        step();
        chk("R8", "lost sticky after read", output_lost, 1'b1);
        ctrl(3'd0, 1'b1);
        chk("R9", "lost cleared by control write", output_lost, 1'b0);

        // Trigger discarded in automatic mode and under NONE
        ctrl(3'd0, 1'b0);
        trig();
        manual_mode = 1'b1; #1;
        wr_in(4'hF);
        step(); step();
        chk("R4", "auto trigger discarded", engine_start, 1'b0);
        ctrl(3'd5, 1'b1);
        wr_in(4'hF);
        trig();
        step();
        chk("R4", "NONE no start", engine_start, 1'b0);
        mode_code = 3'd0; #1;
        step();
        chk("R4", "NONE trigger discarded", engine_start, 1'b0);
        expect_start_next();
        trig();
        chk("R4", "fresh trigger starts", engine_start, 1'b1);
        step();
        finish_eng();
        step();

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing starts actual=%0d expected=0", exp_q.size());
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule